// File: doc/BRIEF.md
# Reciprocal-Table 8-bit Unsigned Divider

This block divides an 8-bit unsigned dividend by an 8-bit unsigned divisor and returns quotient, remainder and a divide-by-zero flag. It has no iterative divider. A reciprocal table is computed at elaboration and indexed by the divisor. The dividend is multiplied by the scaled reciprocal to a 32-bit product, and the product is shifted right by 16. The remainder comes from multiplying the quotient back by the divisor and subtracting the result from the dividend.

The block accepts requests over a valid/ready handshake and returns responses over a second valid/ready handshake. There are two register stages. The first stage captures the operands and the table word. The second stage holds the multiply, shift and remainder results. When the consumer holds back, the pipeline stalls without losing results. A constant-divisor variant, chosen by parameter, replaces the table with a fixed multiplier and shift, for example 171 and 9 for a divisor of 3.

Top module: `recip_div8`

## Requirements
- R1: With the default parameters (variable divisor) and a divisor `a` from 1 to 255, `out_quot` equals floor(dividend / a) for every dividend from 0 to 255.
- R2: The table word for divisor `a` is ceil(65536 / a) - 1, and one is added back before the multiply. At the table extremes this gives the following: divisor 1 returns the dividend as quotient with remainder 0, and divisor 255 returns quotient 1 only for dividend 255 and quotient 0 otherwise.
- R3: For a non-zero divisor, `out_rem` equals the dividend minus quotient times divisor, and is less than the divisor.
- R4: A divisor of 0 returns `out_quot` = 255 and `out_rem` = dividend, with `out_dbz` = 1. For every non-zero divisor, `out_dbz` = 0.
- R5: A request accepted on clock edge k is presented on `out_valid` after edge k+1 when the output is free. When both stages are full and `out_ready` is low, `in_ready` is low. With `out_ready` high, one request is accepted per cycle.
- R6: While `out_valid` is high and `out_ready` is low, the outputs `out_quot`, `out_rem` and `out_dbz` hold their values. Results leave in request order, none is lost and none is repeated.
- R7: With `FIXED_DIVISOR`=3, `FIXED_MULT`=171 and `FIXED_SHIFT`=9, the quotient is floor(x/3) and the remainder is x mod 3 for every dividend x. `in_divisor` has no effect in this mode, including the value 0, and `out_dbz` stays 0.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_dividend | input | DATA_W | Dividend |
| in_divisor | input | DATA_W | Divisor (ignored in constant-divisor mode) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_quot | output | DATA_W | Quotient |
| out_rem | output | DATA_W | Remainder |
| out_dbz | output | 1 | Divisor was zero |

## Verification
A new request can be accepted in the same cycle that a finished result sits stalled at the output. In that case the first stage has to fill while the second stage freezes. To provoke this, the bench drops `out_ready` at random about one cycle in eight while it streams all 65536 dividend/divisor pairs back to back. A directed sequence then fills both stages and confirms that `in_ready` falls. The result is judged by the scoreboard: each response must match the next expected item in order, and the outputs must not change on any stalled cycle.

// File: rtl/recip_div8_pkg.sv
package recip_div8_pkg;

  // Scaled reciprocal minus one: ceil(2**scale / den) - 1; zero for den == 0.
  function automatic logic [31:0] recip_word(input int unsigned den,
                                             input int unsigned scale);
    longint unsigned full;
    longint unsigned ceil_q;
    full = 64'd1 << scale;
    if (den == 0) begin
      return 32'd0;
    end
    ceil_q = (full + longint'(den) - 1) / longint'(den);
    return 32'(ceil_q - 1);
  endfunction

endpackage

// File: rtl/recip_table.sv
module recip_table #(
  parameter int DATA_W  = 8,
  parameter int ENTRY_W = 16
) (
  input  logic [DATA_W-1:0]  idx,
  output logic [ENTRY_W-1:0] word
);
  import recip_div8_pkg::*;

  localparam int DEPTH = 1 << DATA_W;

  logic [ENTRY_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam logic [31:0] VAL = recip_word(g, ENTRY_W);
    assign rom[g] = VAL[ENTRY_W-1:0];
  end

  assign word = rom[idx];

endmodule

// File: rtl/recip_div8_s1.sv
module recip_div8_s1 #(
  parameter int DATA_W  = 8,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [DATA_W-1:0]  up_dividend,
  input  logic [DATA_W-1:0]  up_divisor,
  input  logic [ENTRY_W-1:0] up_word,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [DATA_W-1:0]  dn_dividend,
  output logic [DATA_W-1:0]  dn_divisor,
  output logic [ENTRY_W-1:0] dn_word
);

  logic valid_q, valid_d;
  logic load_en;

  assign up_ready = !valid_q || dn_ready;
  assign load_en  = up_valid && up_ready;

  always_comb begin
    valid_d = valid_q;
    if (up_ready) begin
      valid_d = up_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      dn_dividend <= up_dividend;
      dn_divisor  <= up_divisor;
      dn_word     <= up_word;
    end
  end

  assign dn_valid = valid_q;

  // R5: an accepted request occupies this stage on the next cycle
  assert_accept_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid);

  // R6: a stalled entry keeps its operands
  assert_s1_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_dividend) && $stable(dn_divisor)));

endmodule

// File: rtl/recip_div8_s2.sv
module recip_div8_s2 #(
  parameter int DATA_W        = 8,
  parameter int ENTRY_W       = 16,
  parameter int FIXED_DIVISOR = 0,
  parameter int FIXED_MULT    = 171,
  parameter int FIXED_SHIFT   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [DATA_W-1:0]  up_dividend,
  input  logic [DATA_W-1:0]  up_divisor,
  input  logic [ENTRY_W-1:0] up_word,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [DATA_W-1:0]  dn_quot,
  output logic [DATA_W-1:0]  dn_rem,
  output logic               dn_dbz
);

  localparam int PROD_W = 2 * ENTRY_W;
  localparam int BACK_W = 2 * DATA_W;
  localparam int RECIP_W = ENTRY_W + 1;

  logic [DATA_W-1:0] quot_c, rem_c, den_c;
  logic              zero_c;
  logic [PROD_W-1:0] prod_c;
  logic [BACK_W-1:0] back_c;
  logic              valid_q, valid_d, load_en;

  if (FIXED_DIVISOR == 0) begin : g_table_mode
    logic [RECIP_W-1:0] recip_c;
    always_comb begin
      recip_c = RECIP_W'(up_word) + RECIP_W'(1);
      prod_c  = PROD_W'(up_dividend) * PROD_W'(recip_c);
      zero_c  = (up_divisor == '0);
      den_c   = up_divisor;
      quot_c  = zero_c ? '1 : DATA_W'(prod_c >> ENTRY_W);
    end
  end else begin : g_fixed_mode
    always_comb begin
      prod_c = PROD_W'(up_dividend) * PROD_W'(FIXED_MULT);
      zero_c = 1'b0;
      den_c  = DATA_W'(FIXED_DIVISOR);
      quot_c = DATA_W'(prod_c >> FIXED_SHIFT);
    end
    // R7: constant-divisor mode never flags a zero divisor
    assert_fixed_no_dbz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> !dn_dbz);
  end

  always_comb begin
    back_c = BACK_W'(quot_c) * BACK_W'(den_c);
    rem_c  = zero_c ? up_dividend : DATA_W'(BACK_W'(up_dividend) - back_c);
  end

  assign up_ready = !valid_q || dn_ready;
  assign load_en  = up_valid && up_ready;

  always_comb begin
    valid_d = valid_q;
    if (up_ready) begin
      valid_d = up_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      dn_quot <= quot_c;
      dn_rem  <= rem_c;
      dn_dbz  <= zero_c;
    end
  end

  assign dn_valid = valid_q;

  // R1: quotient and remainder recompose the dividend
  assert_recompose_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !zero_c) |-> (BACK_W'(back_c + BACK_W'(rem_c)) == BACK_W'(up_dividend)));

  // R3: remainder stays below the divisor
  assert_rem_below_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !zero_c) |-> (rem_c < den_c));

endmodule

// File: rtl/recip_div8.sv
module recip_div8 #(
  parameter int DATA_W        = 8,
  parameter int FIXED_DIVISOR = 0,
  parameter int FIXED_MULT    = 171,
  parameter int FIXED_SHIFT   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_dividend,
  input  logic [DATA_W-1:0] in_divisor,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_quot,
  output logic [DATA_W-1:0] out_rem,
  output logic              out_dbz
);

  localparam int ENTRY_W = 2 * DATA_W;

  logic [ENTRY_W-1:0] tbl_word;
  logic               s1_valid, s2_ready;
  logic [DATA_W-1:0]  s1_dividend, s1_divisor;
  logic [ENTRY_W-1:0] s1_word;

  recip_table #(
    .DATA_W (DATA_W),
    .ENTRY_W(ENTRY_W)
  ) u_table (
    .idx (in_divisor),
    .word(tbl_word)
  );

  recip_div8_s1 #(
    .DATA_W (DATA_W),
    .ENTRY_W(ENTRY_W)
  ) u_s1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (in_valid),
    .up_ready   (in_ready),
    .up_dividend(in_dividend),
    .up_divisor (in_divisor),
    .up_word    (tbl_word),
    .dn_valid   (s1_valid),
    .dn_ready   (s2_ready),
    .dn_dividend(s1_dividend),
    .dn_divisor (s1_divisor),
    .dn_word    (s1_word)
  );

  recip_div8_s2 #(
    .DATA_W       (DATA_W),
    .ENTRY_W      (ENTRY_W),
    .FIXED_DIVISOR(FIXED_DIVISOR),
    .FIXED_MULT   (FIXED_MULT),
    .FIXED_SHIFT  (FIXED_SHIFT)
  ) u_s2 (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (s1_valid),
    .up_ready   (s2_ready),
    .up_dividend(s1_dividend),
    .up_divisor (s1_divisor),
    .up_word    (s1_word),
    .dn_valid   (out_valid),
    .dn_ready   (out_ready),
    .dn_quot    (out_quot),
    .dn_rem     (out_rem),
    .dn_dbz     (out_dbz)
  );

  // R6: a stalled result does not change
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_quot) && $stable(out_rem) && $stable(out_dbz)));

  // R4: a zero-divisor result carries the saturated quotient
  assert_dbz_quot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dbz) |-> (out_quot == '1));

  // R5: with both stages full and the consumer stalled, no request is taken
  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/recip_div8_bench.sv
module recip_div8_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int WATCHDOG   = 190000;

  typedef struct {
    int x;
    int a;
    int q;
    int r;
    int z;
  } exp_t;

  logic         clk, rst_n;
  logic         in_valid, in_ready, out_valid, out_ready, out_dbz;
  logic [W-1:0] in_dividend, in_divisor, out_quot, out_rem;
  logic         k_in_valid, k_in_ready, k_out_valid, k_out_dbz;
  logic [W-1:0] k_in_dividend, k_in_divisor, k_out_quot, k_out_rem;

  exp_t exp_q[$];
  exp_t kexp_q[$];
  int   checks, errors;
  bit   stall_en, force_block;

  recip_div8 #(.DATA_W(W)) u_recip_div8 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_quot(out_quot), .out_rem(out_rem), .out_dbz(out_dbz)
  );

  recip_div8 #(.DATA_W(W), .FIXED_DIVISOR(3), .FIXED_MULT(171), .FIXED_SHIFT(9)) u_recip_div8_k3 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(k_in_valid), .in_ready(k_in_ready),
    .in_dividend(k_in_dividend), .in_divisor(k_in_divisor),
    .out_valid(k_out_valid), .out_ready(1'b1),
    .out_quot(k_out_quot), .out_rem(k_out_rem), .out_dbz(k_out_dbz)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic exp_t model(input int x, input int a);
    exp_t e;
    e.x = x; e.a = a;
    if (a == 0) begin
      e.q = 255; e.r = x; e.z = 1;
    end else begin
      e.q = x / a; e.r = x % a; e.z = 0;
    end
    return e;
  endfunction

  // Monitor for the table-mode instance; also owns out_ready.
  initial begin
    logic [W-1:0] hq, hr;
    logic         hz;
    bit           hold_pending;
    exp_t         e;
    string        qtag;
    hold_pending = 0;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (hold_pending) begin
        chk("R6", "stalled quotient", int'(out_quot), int'(hq));
        chk("R6", "stalled remainder", int'(out_rem), int'(hr));
        chk("R6", "stalled dbz", int'(out_dbz), int'(hz));
      end
      out_ready = force_block ? 1'b0 : (stall_en ? ($urandom_range(7) != 0) : 1'b1);
      hold_pending = rst_n && out_valid && !out_ready;
      hq = out_quot; hr = out_rem; hz = out_dbz;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R6", "unexpected result count", 1, 0);
        end else begin
          e = exp_q.pop_front();
          qtag = (e.a == 0) ? "R4" : ((e.a == 1 || e.a == 255) ? "R2" : "R1");
          chk(qtag, $sformatf("quotient %0d/%0d", e.x, e.a), int'(out_quot), e.q);
          chk((e.a == 0) ? "R4" : "R3", $sformatf("remainder %0d/%0d", e.x, e.a), int'(out_rem), e.r);
          chk("R4", $sformatf("dbz flag divisor %0d", e.a), int'(out_dbz), e.z);
        end
      end
    end
  end

  // Monitor for the constant-divisor instance (out_ready tied high).
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && k_out_valid) begin
        if (kexp_q.size() == 0) begin
          chk("R7", "unexpected result count", 1, 0);
        end else begin
          e = kexp_q.pop_front();
          chk("R7", $sformatf("fixed quotient %0d", e.x), int'(k_out_quot), e.q);
          chk("R7", $sformatf("fixed remainder %0d", e.x), int'(k_out_rem), e.r);
          chk("R7", $sformatf("fixed dbz divisor-in %0d", e.a), int'(k_out_dbz), 0);
        end
      end
    end
  end

  task automatic send(input int x, input int a);
    @(negedge clk);
    in_valid = 1'b1;
    in_dividend = W'(x);
    in_divisor = W'(a);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(x, a));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    checks = 0; errors = 0;
    stall_en = 0; force_block = 0;
    in_valid = 0; in_dividend = '0; in_divisor = '0;
    k_in_valid = 0; k_in_dividend = '0; k_in_divisor = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R8: reset state
    @(negedge clk);
    #1;
    chk("R8", "out_valid after reset", int'(out_valid), 0);
    chk("R8", "in_ready after reset", int'(in_ready), 1);

    // R5: two-edge latency
    send(100, 7);
    @(negedge clk);
    chk("R5", "out_valid one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    chk("R5", "out_valid two edges after accept", int'(out_valid), 1);
    repeat (2) @(negedge clk);

    // R5/R6: fill both stages with the consumer blocked
    force_block = 1;
    send(200, 9);
    send(0, 0);
    @(negedge clk);
    in_valid = 1'b1; in_dividend = 8'd77; in_divisor = 8'd5;
    #1;
    chk("R5", "in_ready with both stages full", int'(in_ready), 0);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    force_block = 0;
    repeat (4) @(negedge clk);

    // R1-style boundary points then exhaustive sweep with random stalls
    send(255, 1);
    send(255, 255);
    send(254, 255);
    send(255, 0);
    stall_en = 1;
    for (int a = 0; a < 256; a++) begin
      for (int x = 0; x < 256; x++) begin
        send(x, a);
      end
    end
    stall_en = 0;
    while (exp_q.size() != 0) @(negedge clk);

    // R7: constant divisor 3, divisor input varied and ignored
    for (int x = 0; x < 256; x++) begin
      @(negedge clk);
      k_in_valid = 1'b1;
      k_in_dividend = W'(x);
      k_in_divisor = W'(x * 7);
      kexp_q.push_back('{x: x, a: (x * 7) % 256, q: x / 3, r: x % 3, z: 0});
    end
    @(negedge clk);
    k_in_valid = 1'b0;
    while (kexp_q.size() != 0) @(negedge clk);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule